// File: doc/BRIEF.md
# Indexed Register Port with Interrupt Status

This block sits between a narrow host bus and the timekeeping logic of a real-time clock. The host sees only two byte addresses. A write to the even address selects one of 128 byte locations; an access to the odd address then reads or writes the selected byte. Most locations are plain storage. A few carry control or status meaning: control byte A holds the divider and rate fields, control byte B holds the interrupt enables and mode bits, status byte C collects event flags, and status byte D is a fixed read-only value.

The periodic, alarm and update-ended events come in as single-cycle pulses from neighbouring blocks. The block latches them into status byte C, derives the summary request bit, and drives a level interrupt. Host writes to the time fields are passed on as a one-cycle strobe with index and data. Changes to control bytes A and B are passed on in the same way, together with their current values.

Top module: `rtc_regport`

## Requirements
- R1: A write to the even address (`bus_sel_i`=0) loads the index with the data masked to 7 bits. A read of the even address returns 0xFF.
- R2: Odd-address accesses (`bus_sel_i`=1) to a location with no special meaning store the written byte and return it on a later read.
- R3: Writes to status byte C (index 0x0C) and status byte D (index 0x0D) have no effect.
- R4: Bit 7 of control byte A (index 0x0A) reads as the current `uip_i` level. A write to byte A stores only data bits 6:0.
- R5: A read of byte C returns its current value, then clears the whole byte to 0x00 and drops `irq_o` on the next cycle, unless a new event arrives in the same cycle.
- R6: Event pulses `evt_i[2]`, `evt_i[1]` and `evt_i[0]` set C bits 6, 5 and 4. C bit 7 (summary request, mirrored on `irq_o`) is set only when a flag goes from 0 to 1 while the B bit at the same position is 1.
- R7: An event whose flag is already set neither changes byte C nor raises `irq_o`.
- R8: A write to control byte B (index 0x0B) sets C bit 7 and raises `irq_o` on the next cycle when the new B bits 6:4 overlap pending C bits 6:4. Otherwise it clears C bit 7 and drops `irq_o`.
- R9: A write to byte B with bit 7 (hold) set stores bit 4 (update-ended enable) as 0.
- R10: After reset, A reads 0x26, B reads 0x02, C reads 0x00, D reads 0x80, and `irq_o` is low.
- R11: A `dev_rst_i` pulse clears B bits 6, 5 and 3, clears all of byte C and drops `irq_o`.
- R12: An odd-address access while the index is 0x32 redirects both the access and the stored index to the century location 0x37.
- R13: A write to a time field (index 0, 2, 4, 6, 7, 8, 9 or the century location) gives a one-cycle `tfield_wr_o` strobe with the index and data on the next cycle. A write to A or B gives a one-cycle `ctl_chg_o` strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_rst_i | input | 1 | Device reset pulse: clears enables and flags |
| bus_sel_i | input | 1 | 0 = index address, 1 = data address |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe (carries read side effects) |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for the current access |
| evt_i | input | 3 | Event pulses: [2] periodic, [1] alarm, [0] update-ended |
| uip_i | input | 1 | Update-in-progress level from the time block |
| irq_o | output | 1 | Level interrupt request |
| tfield_wr_o | output | 1 | Time-field write strobe |
| fwd_idx_o | output | 7 | Index of the forwarded write |
| fwd_data_o | output | 8 | Data of the forwarded write |
| ctl_chg_o | output | 1 | Control byte A or B written |
| ctl_a_o | output | 7 | Stored bits 6:0 of control byte A |
| ctl_b_o | output | 8 | Control byte B |

## Verification
The bench targets the points where flags and enables meet. It raises a flag with its enable off and then turns the enable on, which a design missing the at-once check would leave silent. It repeats an event whose flag is already set, where a design without edge detection on flags would reassert a request that had been dropped. It reads C to check that one read both returns and clears the byte, and it writes to C and D to catch a decoder that lets those bytes change. It also writes B with the hold bit and the update-ended enable both set, uses the 0x32 alias, and holds `uip_i` high during a write to A, each of which would return a wrong read-back byte if handled wrongly.

// File: rtl/rtc_regport_pkg.sv
package rtc_regport_pkg;
  // Bit positions inside control byte B; C flags share positions 6:4.
  localparam int B_HOLD = 7;
  localparam int B_PER  = 6;
  localparam int B_ALM  = 5;
  localparam int B_UPD  = 4;
  localparam int B_SQW  = 3;
  localparam int C_REQ  = 7;

  typedef enum logic [2:0] {
    K_PLAIN,
    K_TIME,
    K_CTLA,
    K_CTLB,
    K_STAT,
    K_FIXED
  } loc_kind_e;
endpackage

// File: rtl/rtc_regport_decode.sv
module rtc_regport_decode
  import rtc_regport_pkg::*;
#(
  parameter int IDX_W       = 7,
  parameter int A_IDX       = 10,
  parameter int B_IDX       = 11,
  parameter int C_IDX       = 12,
  parameter int D_IDX       = 13,
  parameter int ALIAS_IDX   = 50,
  parameter int CENT_IDX    = 55,
  parameter logic [15:0] TIME_LO_MAP = 16'h03D5
) (
  input  logic [IDX_W-1:0] idx_i,
  output logic [IDX_W-1:0] eff_idx_o,
  output logic             alias_hit_o,
  output loc_kind_e        kind_o
);
  always_comb begin
    alias_hit_o = (idx_i == IDX_W'(ALIAS_IDX));
    eff_idx_o   = alias_hit_o ? IDX_W'(CENT_IDX) : idx_i;
    if (eff_idx_o == IDX_W'(A_IDX))      kind_o = K_CTLA;
    else if (eff_idx_o == IDX_W'(B_IDX)) kind_o = K_CTLB;
    else if (eff_idx_o == IDX_W'(C_IDX)) kind_o = K_STAT;
    else if (eff_idx_o == IDX_W'(D_IDX)) kind_o = K_FIXED;
    else if (eff_idx_o == IDX_W'(CENT_IDX)) kind_o = K_TIME;
    else if ((eff_idx_o < IDX_W'(16)) && TIME_LO_MAP[eff_idx_o[3:0]]) kind_o = K_TIME;
    else kind_o = K_PLAIN;
  end
endmodule

// File: rtl/rtc_regport_store.sv
module rtc_regport_store
  import rtc_regport_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int IDX_W = 7,
  parameter int A_IDX = 10,
  parameter int B_IDX = 11,
  parameter int C_IDX = 12,
  parameter int D_IDX = 13,
  parameter logic [7:0] A_RST = 8'h26,
  parameter logic [7:0] B_RST = 8'h02,
  parameter logic [7:0] D_RST = 8'h80
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dev_rst_i,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [7:0]       wdata_i,
  output logic [7:0]       rdata_o,
  output logic [7:0]       a_o,
  output logic [7:0]       b_o
);
  localparam logic [7:0] DEVRST_KEEP = ~(8'(1) << B_PER | 8'(1) << B_ALM | 8'(1) << B_SQW);

  logic [7:0] byte_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_byte
    localparam logic [7:0] RV = (g == A_IDX) ? A_RST :
                                (g == B_IDX) ? B_RST :
                                (g == D_IDX) ? D_RST : 8'h00;
    localparam bit WRITABLE = (g != C_IDX) && (g != D_IDX);
    logic [7:0] q;
    logic [7:0] nxt;
    logic       en;

    always_comb begin
      nxt = q;
      en  = WRITABLE && wr_en_i && (idx_i == IDX_W'(g));
      if (en) begin
        if (g == A_IDX) nxt = {1'b0, wdata_i[6:0]};
        else            nxt = wdata_i;
      end
      if (dev_rst_i && (g == B_IDX)) nxt = nxt & DEVRST_KEEP;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= RV;
      else        q <= nxt;
    end

    assign byte_q[g] = q;
  end

  assign rdata_o = byte_q[idx_i];
  assign a_o     = byte_q[A_IDX];
  assign b_o     = byte_q[B_IDX];
endmodule

// File: rtl/rtc_regport_flags.sv
module rtc_regport_flags
  import rtc_regport_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dev_rst_i,
  input  logic [2:0] evt_i,
  input  logic       rd_clr_i,
  input  logic       b_wr_i,
  input  logic [7:0] b_new_i,
  input  logic [7:0] b_cur_i,
  output logic [7:0] stat_o,
  output logic       irq_o
);
  logic [7:0] stat_q, stat_d;
  logic [2:0] raised;
  logic [7:0] b_eff;

  always_comb begin
    b_eff  = b_wr_i ? b_new_i : b_cur_i;
    stat_d = stat_q;
    if (b_wr_i) stat_d[C_REQ] = |(b_new_i[6:4] & stat_q[6:4]);
    if (rd_clr_i) stat_d = 8'h00;
    raised      = evt_i & ~stat_d[6:4];
    stat_d[6:4] = stat_d[6:4] | evt_i;
    if (|(raised & b_eff[6:4])) stat_d[C_REQ] = 1'b1;
    if (dev_rst_i) stat_d = 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= 8'h00;
    else        stat_q <= stat_d;
  end

  assign stat_o = stat_q;
  assign irq_o  = stat_q[C_REQ];
endmodule

// File: rtl/rtc_regport.sv
module rtc_regport
  import rtc_regport_pkg::*;
#(
  parameter int DEPTH     = 128,
  parameter int A_IDX     = 10,
  parameter int B_IDX     = 11,
  parameter int C_IDX     = 12,
  parameter int D_IDX     = 13,
  parameter int ALIAS_IDX = 50,
  parameter int CENT_IDX  = 55
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dev_rst_i,
  input  logic       bus_sel_i,
  input  logic       bus_wr_i,
  input  logic       bus_rd_i,
  input  logic [7:0] bus_wdata_i,
  output logic [7:0] bus_rdata_o,
  input  logic [2:0] evt_i,
  input  logic       uip_i,
  output logic       irq_o,
  output logic       tfield_wr_o,
  output logic [6:0] fwd_idx_o,
  output logic [7:0] fwd_data_o,
  output logic       ctl_chg_o,
  output logic [6:0] ctl_a_o,
  output logic [7:0] ctl_b_o
);
  localparam int IDX_W = $clog2(DEPTH);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sn = rst_sync_q[1];

  logic [IDX_W-1:0] idx_q, idx_d, eff_idx;
  logic             alias_hit;
  loc_kind_e        kind;
  logic             data_wr, data_rd, data_acc;
  logic [7:0]       wval, store_rd, a_byte, b_byte, stat;
  logic             tf_q, tf_d, cc_q, cc_d;
  logic [6:0]       fi_q, fi_d;
  logic [7:0]       fd_q, fd_d;

  rtc_regport_decode #(
    .IDX_W(IDX_W), .A_IDX(A_IDX), .B_IDX(B_IDX), .C_IDX(C_IDX),
    .D_IDX(D_IDX), .ALIAS_IDX(ALIAS_IDX), .CENT_IDX(CENT_IDX)
  ) u_dec (
    .idx_i(idx_q), .eff_idx_o(eff_idx), .alias_hit_o(alias_hit), .kind_o(kind)
  );

  always_comb begin
    data_wr  = bus_wr_i & bus_sel_i;
    data_rd  = bus_rd_i & bus_sel_i;
    data_acc = data_wr | data_rd;
    wval     = bus_wdata_i;
    if (kind == K_CTLB && bus_wdata_i[B_HOLD]) wval[B_UPD] = 1'b0;
    idx_d = idx_q;
    if (bus_wr_i && !bus_sel_i) idx_d = bus_wdata_i[IDX_W-1:0];
    else if (data_acc && alias_hit) idx_d = eff_idx;
    tf_d = data_wr && (kind == K_TIME);
    cc_d = data_wr && (kind == K_CTLA || kind == K_CTLB);
    fi_d = fi_q;
    fd_d = fd_q;
    if (tf_d) begin
      fi_d = 7'(eff_idx);
      fd_d = wval;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      idx_q <= '0;
      tf_q  <= 1'b0;
      cc_q  <= 1'b0;
      fi_q  <= '0;
      fd_q  <= '0;
    end else begin
      idx_q <= idx_d;
      tf_q  <= tf_d;
      cc_q  <= cc_d;
      fi_q  <= fi_d;
      fd_q  <= fd_d;
    end
  end

  rtc_regport_store #(
    .DEPTH(DEPTH), .IDX_W(IDX_W), .A_IDX(A_IDX), .B_IDX(B_IDX),
    .C_IDX(C_IDX), .D_IDX(D_IDX)
  ) u_store (
    .clk(clk), .rst_n(rst_sn), .dev_rst_i(dev_rst_i), .wr_en_i(data_wr),
    .idx_i(eff_idx), .wdata_i(wval), .rdata_o(store_rd),
    .a_o(a_byte), .b_o(b_byte)
  );

  rtc_regport_flags u_flags (
    .clk(clk), .rst_n(rst_sn), .dev_rst_i(dev_rst_i), .evt_i(evt_i),
    .rd_clr_i(data_rd && kind == K_STAT),
    .b_wr_i(data_wr && kind == K_CTLB), .b_new_i(wval), .b_cur_i(b_byte),
    .stat_o(stat), .irq_o(irq_o)
  );

  always_comb begin
    if (!bus_sel_i)          bus_rdata_o = 8'hFF;
    else if (kind == K_STAT) bus_rdata_o = stat;
    else if (kind == K_CTLA) bus_rdata_o = {uip_i, a_byte[6:0]};
    else                     bus_rdata_o = store_rd;
  end

  assign tfield_wr_o = tf_q;
  assign fwd_idx_o   = fi_q;
  assign fwd_data_o  = fd_q;
  assign ctl_chg_o   = cc_q;
  assign ctl_a_o     = a_byte[6:0];
  assign ctl_b_o     = b_byte;
endmodule

// File: rtl/rtc_regport_chk.sv
module rtc_regport_chk #(
  parameter int IDX_W     = 7,
  parameter int C_IDX     = 12,
  parameter int ALIAS_IDX = 50,
  parameter int CENT_IDX  = 55
) (
  input logic             clk,
  input logic             rst_sn,
  input logic             dev_rst_i,
  input logic             bus_sel_i,
  input logic             bus_wr_i,
  input logic             bus_rd_i,
  input logic [7:0]       bus_wdata_i,
  input logic [2:0]       evt_i,
  input logic [IDX_W-1:0] idx_q,
  input logic             irq_o,
  input logic [7:0]       ctl_b_o
);
  p_idx_load_r1: assert property (@(posedge clk) disable iff (!rst_sn)
    (bus_wr_i && !bus_sel_i) |=> idx_q == $past(bus_wdata_i[IDX_W-1:0]));

  p_stat_read_clear_r5: assert property (@(posedge clk) disable iff (!rst_sn)
    (bus_rd_i && bus_sel_i && !bus_wr_i && !dev_rst_i &&
     idx_q == IDX_W'(C_IDX) && evt_i == 3'b000) |=> !irq_o);

  p_irq_has_cause_r6: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(irq_o) |-> $past(evt_i != 3'b000 || (bus_wr_i && bus_sel_i)));

  p_hold_masks_upd_r9: assert property (@(posedge clk) disable iff (!rst_sn)
    ctl_b_o[7] |-> !ctl_b_o[4]);

  p_devrst_clears_r11: assert property (@(posedge clk) disable iff (!rst_sn)
    dev_rst_i |=> (!irq_o && ctl_b_o[6:5] == 2'b00 && !ctl_b_o[3]));

  p_alias_redirect_r12: assert property (@(posedge clk) disable iff (!rst_sn)
    ((bus_wr_i || bus_rd_i) && bus_sel_i && idx_q == IDX_W'(ALIAS_IDX))
      |=> idx_q == IDX_W'(CENT_IDX));
endmodule

bind rtc_regport rtc_regport_chk #(
  .IDX_W(IDX_W), .C_IDX(C_IDX), .ALIAS_IDX(ALIAS_IDX), .CENT_IDX(CENT_IDX)
) u_chk (
  .clk(clk), .rst_sn(rst_sn), .dev_rst_i(dev_rst_i), .bus_sel_i(bus_sel_i),
  .bus_wr_i(bus_wr_i), .bus_rd_i(bus_rd_i), .bus_wdata_i(bus_wdata_i),
  .evt_i(evt_i), .idx_q(idx_q), .irq_o(irq_o), .ctl_b_o(ctl_b_o)
);

// File: tb/rtc_regport_tb.sv
module rtc_regport_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dev_rst_i = 1'b0;
  logic       bus_sel_i = 1'b0;
  logic       bus_wr_i = 1'b0;
  logic       bus_rd_i = 1'b0;
  logic [7:0] bus_wdata_i = 8'h00;
  logic [7:0] bus_rdata_o;
  logic [2:0] evt_i = 3'b000;
  logic       uip_i = 1'b0;
  logic       irq_o, tfield_wr_o, ctl_chg_o;
  logic [6:0] fwd_idx_o, ctl_a_o;
  logic [7:0] fwd_data_o, ctl_b_o;

  int total = 0;
  int bad   = 0;
  logic [7:0] exp_q [$];
  string      tag_q [$];

  always #5 clk = ~clk;

  rtc_regport u_dut (
    .clk(clk), .rst_n(rst_n), .dev_rst_i(dev_rst_i), .bus_sel_i(bus_sel_i),
    .bus_wr_i(bus_wr_i), .bus_rd_i(bus_rd_i), .bus_wdata_i(bus_wdata_i),
    .bus_rdata_o(bus_rdata_o), .evt_i(evt_i), .uip_i(uip_i), .irq_o(irq_o),
    .tfield_wr_o(tfield_wr_o), .fwd_idx_o(fwd_idx_o), .fwd_data_o(fwd_data_o),
    .ctl_chg_o(ctl_chg_o), .ctl_a_o(ctl_a_o), .ctl_b_o(ctl_b_o)
  );

  // monitor: compares read data against the scoreboard queue mid low phase
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (bus_rd_i && exp_q.size() > 0) begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        total++;
        if (bus_rdata_o !== e) begin
          bad++;
          $display("FAIL %s read: got %02h expected %02h", t, bus_rdata_o, e);
        end
      end
    end
  end

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk);
    bus_sel_i = sel; bus_wr_i = 1'b1; bus_wdata_i = d;
    @(negedge clk);
    bus_wr_i = 1'b0;
  endtask

  task automatic rd(input logic sel, input logic [7:0] e, input string t);
    @(negedge clk);
    exp_q.push_back(e); tag_q.push_back(t);
    bus_sel_i = sel; bus_rd_i = 1'b1;
    @(negedge clk);
    bus_rd_i = 1'b0;
  endtask

  task automatic rdi(input logic [7:0] idx, input logic [7:0] e, input string t);
    wr(1'b0, idx);
    rd(1'b1, e, t);
  endtask

  task automatic wri(input logic [7:0] idx, input logic [7:0] d);
    wr(1'b0, idx);
    wr(1'b1, d);
  endtask

  task automatic pulse_evt(input logic [2:0] e);
    @(negedge clk);
    evt_i = e;
    @(negedge clk);
    evt_i = 3'b000;
  endtask

  task automatic chk(input logic [15:0] act, input logic [15:0] e, input string t);
    #2;
    total++;
    if (act !== e) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h", t, act, e);
    end
  endtask

  initial begin
    #2_000_000;
    bad++;
    total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10 reset contents
    chk(16'(irq_o), 16'h0, "R10 irq after reset");
    rdi(8'h0A, 8'h26, "R10 A");
    rdi(8'h0B, 8'h02, "R10 B");
    rdi(8'h0C, 8'h00, "R10 C");
    rdi(8'h0D, 8'h80, "R10 D");

    // R1 index masking and even read
    rd(1'b0, 8'hFF, "R1 even read");
    wri(8'hA5, 8'h5A);                 // index 0x25
    rdi(8'h25, 8'h5A, "R1 masked index");
    // R2 plain storage
    wri(8'h40, 8'hC3);
    wri(8'h7F, 8'h3C);
    rdi(8'h40, 8'hC3, "R2 byte 0x40");
    rdi(8'h7F, 8'h3C, "R2 byte 0x7F");

    // R3 C and D ignore writes
    wri(8'h0C, 8'hFF);
    wri(8'h0D, 8'h00);
    chk(16'(irq_o), 16'h0, "R3 irq after C write");
    rdi(8'h0C, 8'h00, "R3 C unchanged");
    rdi(8'h0D, 8'h80, "R3 D unchanged");

    // R4 update-in-progress bit is read-only
    uip_i = 1'b1;
    wri(8'h0A, 8'h00);
    chk(16'(ctl_chg_o), 16'h1, "R13 ctl strobe on A write");
    rd(1'b1, 8'h80, "R4 A with uip high");
    uip_i = 1'b0;
    rd(1'b1, 8'h00, "R4 A with uip low");
    wr(1'b1, 8'hAF);
    chk(16'(ctl_a_o), 16'h2F, "R4 A stored bits");
    wr(1'b1, 8'h26);

    // R6 flag without enable: no request
    pulse_evt(3'b100);
    chk(16'(irq_o), 16'h0, "R6 no irq when disabled");
    rdi(8'h0C, 8'h40, "R6 periodic flag");
    rd(1'b1, 8'h00, "R5 C cleared by read");

    // R6 enabled flag raises request; R7 repeat event changes nothing
    wri(8'h0B, 8'h42);
    chk(16'(irq_o), 16'h0, "R8 no pending on enable");
    pulse_evt(3'b100);
    chk(16'(irq_o), 16'h1, "R6 irq on enabled flag");
    wr(1'b0, 8'h0C);
    rd(1'b1, 8'hC0, "R5 C returns value");
    chk(16'(irq_o), 16'h0, "R5 irq dropped by read");
    pulse_evt(3'b100);
    chk(16'(irq_o), 16'h1, "R6 irq again after clear");
    wri(8'h0B, 8'h02);                 // disable: clears request bit
    chk(16'(irq_o), 16'h0, "R8 disable drops irq");
    wri(8'h0B, 8'h42);                 // re-enable: pending flag raises at once
    chk(16'(irq_o), 16'h1, "R8 enable with pending flag");
    wri(8'h0B, 8'h02);
    pulse_evt(3'b100);                 // flag still set: R7
    chk(16'(irq_o), 16'h0, "R7 repeat event ignored");
    rdi(8'h0C, 8'h40, "R7 C unchanged");

    // R8 alarm pending, then enabled
    pulse_evt(3'b010);
    chk(16'(irq_o), 16'h0, "R8 alarm pending no irq");
    wri(8'h0B, 8'h22);
    chk(16'(irq_o), 16'h1, "R8 irq at once on enable");
    rdi(8'h0C, 8'hA0, "R8 C request and alarm");
    wri(8'h0B, 8'h02);
    pulse_evt(3'b001);
    wri(8'h0B, 8'h12);
    chk(16'(irq_o), 16'h1, "R8 update enable raises");
    wri(8'h0B, 8'h02);
    chk(16'(irq_o), 16'h0, "R8 no overlap clears");
    rdi(8'h0C, 8'h10, "R8 request bit cleared");

    // R9 hold forces update-ended enable off
    wri(8'h0B, 8'h92);
    rd(1'b1, 8'h82, "R9 B with hold");
    chk(16'(ctl_b_o), 16'h82, "R9 ctl_b output");

    // R11 device reset
    wri(8'h0B, 8'h6A);
    pulse_evt(3'b100);
    chk(16'(irq_o), 16'h1, "R11 irq before device reset");
    @(negedge clk); dev_rst_i = 1'b1;
    @(negedge clk); dev_rst_i = 1'b0;
    chk(16'(irq_o), 16'h0, "R11 irq after device reset");
    rdi(8'h0B, 8'h02, "R11 B enables cleared");
    rdi(8'h0C, 8'h00, "R11 C cleared");

    // R12 alias index redirects to century location
    wri(8'h32, 8'h20);
    chk(16'(tfield_wr_o), 16'h1, "R13 strobe on century");
    chk(16'(fwd_idx_o), 16'h37, "R12 forwarded index");
    rd(1'b1, 8'h20, "R12 index moved to century");
    rdi(8'h37, 8'h20, "R12 century location");

    // R13 time field forwarding
    wri(8'h04, 8'h59);
    chk(16'(tfield_wr_o), 16'h1, "R13 strobe on time write");
    chk(16'({fwd_idx_o, fwd_data_o}), 16'({7'h04, 8'h59}), "R13 index and data");
    @(negedge clk);
    chk(16'(tfield_wr_o), 16'h0, "R13 strobe one cycle");
    wri(8'h41, 8'h11);
    chk(16'(tfield_wr_o), 16'h0, "R13 no strobe on plain byte");

    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule